// File: doc/BRIEF.md
# Latched Push-Pull PWM Controller

A digital regulating pulse width modulator for a switching supply. A counter runs the period in two phases: a ramp phase, whose count is compared with a duty demand, and a deadtime phase, during which both outputs are off. A pulse that has ended in a period cannot restart before the deadtime, because a latch set at the end of the pulse is cleared only by the deadtime phase. A steering flip-flop gives alternate periods to output A and output B, so the block can drive a push-pull or half-bridge stage directly.

The demand used by the comparator is the smaller of the external demand and a soft-start value. The soft-start value rises by a programmable step at each period start. Shutdown turns the outputs off and pulls the soft-start value down at twice that rate, so turn-on after release is slow. Undervoltage lockout holds the outputs off and keeps the soft-start value at zero. A sync input ends the ramp early, which lets one block follow another or a system clock. A comparator-pulldown input ends the current pulse without touching soft-start. A parameter selects whether an off output is low or high.

Top module: `pwm_pushpull_ctrl`

## Requirements
- R1: While reset is asserted both outputs are at the off level, and after reset the first pulse is on output A.
- R2: In a ramp phase of length L, an output is on for min(demand_i, soft-start value, L) cycles from the start of the ramp. It appears one cycle after the comparator decision.
- R3: Output A and output B are used on alternate periods and are never on in the same cycle.
- R4: Each period ends with dead_len_i deadtime cycles in which both outputs are off. ramp_len_i and dead_len_i are sampled at each period start, and a value of 0 counts as 1.
- R5: Once a pulse has ended within a period, including through a one-cycle pulldown_i, it stays off until the next period. The next period's pulse is unaffected.
- R6: sync_i high in a ramp cycle ends the ramp, and deadtime begins on the next cycle. sync_i is ignored during deadtime.
- R7: With OFF_HIGH=0 an on output is 1 and an off output is 0. With OFF_HIGH=1 each output is the inverse of that.
- R8: shutdown_i high turns both outputs off from the next cycle, and they stay off for the rest of that period.
- R9: At each period start the soft-start value increases by ss_step_i, saturating at all ones. While shutdown_i is high it decreases by 2*ss_step_i instead, saturating at 0.
- R10: While uvlo_i is high both outputs are off from the next cycle, and the soft-start value is 0.
- R11: A demand of 0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Ends the current ramp phase |
| shutdown_i | input | 1 | Turns outputs off and discharges soft-start |
| uvlo_i | input | 1 | Undervoltage lockout |
| pulldown_i | input | 1 | Ends the pulse for the rest of the period |
| demand_i | input | W | Duty demand in ramp counts |
| ramp_len_i | input | W | Ramp phase length in cycles |
| dead_len_i | input | W | Deadtime phase length in cycles |
| ss_step_i | input | W | Soft-start step per period |
| out_a_o | output | 1 | Drive output A |
| out_b_o | output | 1 | Drive output B |

## Verification
Every output is registered, so a comparator, shutdown, lockout or pulldown decision made in cycle n shows on the pins in cycle n+1. The bench samples on the falling edge and counts from the sample at which it observed a rise. Soft-start and configuration act only at period starts. The bench therefore checks those effects as pulse lengths of successive periods (2, 4, 6, 8, 10 for a step of 2). For shutdown it holds the input for a window of exactly two periods, so exactly two discharge steps fall inside it whatever the phase. Duty, deadtime and sync are checked as totals over windows that are whole multiples of two periods, so the phase at which a window opens does not change the expected counts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {PH_RAMP = 1'b0, PH_DEAD = 1'b1} phase_e;
endpackage

// File: rtl/pwm_osc.sv
module pwm_osc
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sync_i,
  input  logic [W-1:0] ramp_len_i,
  input  logic [W-1:0] dead_len_i,
  output logic [W-1:0] cnt_o,
  output logic         dead_o,
  output logic         wrap_o
);
  phase_e       ph_q;
  logic [W-1:0] cnt_q, ramp_q, dead_q;
  logic [W-1:0] ramp_end, dead_end;

  // length 0 behaves as 1
  assign ramp_end = (ramp_q == '0) ? '0 : ramp_q - 1'b1;
  assign dead_end = (dead_q == '0) ? '0 : dead_q - 1'b1;

  assign cnt_o  = cnt_q;
  assign dead_o = (ph_q == PH_DEAD);
  assign wrap_o = (ph_q == PH_DEAD) && (cnt_q == dead_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_DEAD;
      cnt_q  <= '0;
      ramp_q <= W'(1);
      dead_q <= W'(1);
    end else if (ph_q == PH_RAMP) begin
      if (sync_i || cnt_q == ramp_end) begin
        ph_q  <= PH_DEAD;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == dead_end) begin
        ph_q   <= PH_RAMP;
        cnt_q  <= '0;
        ramp_q <= ramp_len_i;
        dead_q <= dead_len_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wrap_i,
  input  logic [W-1:0] step_i,
  input  logic         sd_i,
  input  logic         uvlo_i,
  output logic [W-1:0] ss_o
);
  localparam logic [W:0] SS_MAX = {1'b0, {W{1'b1}}};

  logic [W-1:0] ss_q;
  logic [W:0]   up_sum, dn_amt;

  assign up_sum = {1'b0, ss_q} + {1'b0, step_i};
  assign dn_amt = {step_i, 1'b0};
  assign ss_o   = ss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ss_q <= '0;
    else if (uvlo_i)          ss_q <= '0;
    else if (wrap_i) begin
      if (sd_i)               ss_q <= ({1'b0, ss_q} > dn_amt) ? W'({1'b0, ss_q} - dn_amt) : '0;
      else if (up_sum > SS_MAX) ss_q <= '1;
      else                    ss_q <= up_sum[W-1:0];
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int W        = 8,
  parameter bit OFF_HIGH = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         dead_i,
  input  logic         wrap_i,
  input  logic [W-1:0] demand_i,
  input  logic [W-1:0] ss_i,
  input  logic         pulldown_i,
  input  logic         sd_i,
  input  logic         uvlo_i,
  output logic         out_a_o,
  output logic         out_b_o
);
  logic [W-1:0] eff;
  logic         end_now, on, latch_q, steer_q, on_a_q, on_b_q;

  assign eff     = (demand_i < ss_i) ? demand_i : ss_i;
  assign end_now = !dead_i && (cnt_i >= eff || pulldown_i || sd_i || uvlo_i);
  assign on      = !dead_i && !latch_q && !end_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      steer_q <= 1'b1;
      on_a_q  <= 1'b0;
      on_b_q  <= 1'b0;
    end else begin
      latch_q <= dead_i ? 1'b0 : (latch_q | end_now);
      if (wrap_i) steer_q <= ~steer_q;
      on_a_q  <= on && !steer_q;
      on_b_q  <= on && steer_q;
    end
  end

  generate
    if (OFF_HIGH) begin : g_or_logic
      assign out_a_o = ~on_a_q;
      assign out_b_o = ~on_b_q;
    end else begin : g_nor_logic
      assign out_a_o = on_a_q;
      assign out_b_o = on_b_q;
    end
  endgenerate
endmodule

// File: rtl/pwm_pushpull_ctrl.sv
module pwm_pushpull_ctrl #(
  parameter int W        = 8,
  parameter bit OFF_HIGH = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sync_i,
  input  logic         shutdown_i,
  input  logic         uvlo_i,
  input  logic         pulldown_i,
  input  logic [W-1:0] demand_i,
  input  logic [W-1:0] ramp_len_i,
  input  logic [W-1:0] dead_len_i,
  input  logic [W-1:0] ss_step_i,
  output logic         out_a_o,
  output logic         out_b_o
);
  logic [W-1:0] cnt, ss_val;
  logic         dead_ph, wrap;

  pwm_osc #(.W(W)) u_osc (
    .clk_i, .rst_ni, .sync_i, .ramp_len_i, .dead_len_i,
    .cnt_o(cnt), .dead_o(dead_ph), .wrap_o(wrap)
  );

  pwm_softstart #(.W(W)) u_ss (
    .clk_i, .rst_ni, .wrap_i(wrap), .step_i(ss_step_i),
    .sd_i(shutdown_i), .uvlo_i, .ss_o(ss_val)
  );

  pwm_out_stage #(.W(W), .OFF_HIGH(OFF_HIGH)) u_out (
    .clk_i, .rst_ni, .cnt_i(cnt), .dead_i(dead_ph), .wrap_i(wrap),
    .demand_i, .ss_i(ss_val), .pulldown_i, .sd_i(shutdown_i), .uvlo_i,
    .out_a_o, .out_b_o
  );
endmodule

// File: rtl/pwm_pushpull_chk.sv
module pwm_pushpull_chk #(
  parameter int W        = 8,
  parameter bit OFF_HIGH = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         shutdown_i,
  input logic         uvlo_i,
  input logic         dead_ph,
  input logic [W-1:0] ss_val,
  input logic         out_a_o,
  input logic         out_b_o
);
  logic on_a, on_b;
  assign on_a = out_a_o ^ OFF_HIGH;
  assign on_b = out_b_o ^ OFF_HIGH;

  // R3
  both_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(on_a && on_b));
  // R4
  dead_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) dead_ph |=> !on_a && !on_b);
  // R8
  sd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) shutdown_i |=> !on_a && !on_b);
  // R9
  sd_ss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_i && !uvlo_i) |=> ss_val <= $past(ss_val));
  // R10
  uvlo_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) uvlo_i |=> !on_a && !on_b);
  // R10
  uvlo_ss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) uvlo_i |=> ss_val == '0);
endmodule

bind pwm_pushpull_ctrl pwm_pushpull_chk #(.W(W), .OFF_HIGH(OFF_HIGH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .shutdown_i(shutdown_i), .uvlo_i(uvlo_i),
  .dead_ph(dead_ph), .ss_val(ss_val), .out_a_o(out_a_o), .out_b_o(out_b_o)
);

// File: tb/sim_pwm_pushpull_ctrl.sv
module sim_pwm_pushpull_ctrl;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync = 0, sd = 0, uvlo = 0, pd = 0;
  logic [W-1:0] demand = 0, rlen = 10, dlen = 2, step = 255;
  logic a, b, a1, b1;
  int n_chk = 0, n_fail = 0, pol_mis = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_pushpull_ctrl #(.W(W), .OFF_HIGH(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .shutdown_i(sd), .uvlo_i(uvlo),
    .pulldown_i(pd), .demand_i(demand), .ramp_len_i(rlen), .dead_len_i(dlen),
    .ss_step_i(step), .out_a_o(a), .out_b_o(b));

  pwm_pushpull_ctrl #(.W(W), .OFF_HIGH(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .shutdown_i(sd), .uvlo_i(uvlo),
    .pulldown_i(pd), .demand_i(demand), .ramp_len_i(rlen), .dead_len_i(dlen),
    .ss_step_i(step), .out_a_o(a1), .out_b_o(b1));

  // R7: inverted-polarity instance must mirror the default one every cycle
  always @(negedge clk) if (a1 !== ~a || b1 !== ~b) pol_mis++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int ha, hb, rises, both_off, overlap, maxrun;
  task automatic observe(input int n, input int sync_every);
    int run = 0;
    logic pa = a, pb = b;
    ha = 0; hb = 0; rises = 0; both_off = 0; overlap = 0; maxrun = 0;
    for (int i = 0; i < n; i++) begin
      sync = (sync_every > 0) && (i % sync_every == 0);
      @(negedge clk);
      ha += int'(a); hb += int'(b);
      if (a && !pa) rises++;
      if (b && !pb) rises++;
      if (!a && !b) both_off++;
      if (a && b) overlap++;
      run = (a || b) ? run + 1 : 0;
      if (run > maxrun) maxrun = run;
      pa = a; pb = b;
    end
    sync = 0;
  endtask

  // waits for the next pulse on either output; returns its length and which (0=A,1=B)
  task automatic next_run(output int len, output int which);
    int t = 0;
    len = -1; which = -1;
    while (!(a || b) && t < 1000) begin @(negedge clk); t++; end
    if (t >= 1000) return;
    which = a ? 0 : 1;
    len = 0;
    while ((which == 0 ? a : b) && t < 2000) begin len++; @(negedge clk); t++; end
  endtask

  task automatic t_reset;
    int len, which;
    demand = 4; rlen = 10; dlen = 2; step = 255;
    repeat (3) @(negedge clk);
    chk("R1 out_a in reset", int'(a), 0);
    chk("R1 out_b in reset", int'(b), 0);
    chk("R7 inverted outputs in reset", int'(a1 & b1), 1);
    rst_n = 1;
    next_run(len, which);
    chk("R1 first pulse output (0=A)", which, 0);
    chk("R2 first pulse length", len, 4);
  endtask

  task automatic t_basic;
    demand = 4; rlen = 10; dlen = 2;
    observe(30, 0);
    observe(120, 0);
    chk("R2 A on-cycles", ha, 20);
    chk("R3 B on-cycles", hb, 20);
    chk("R3 overlap", overlap, 0);
    chk("R3 pulses per window", rises, 10);
    chk("R2 pulse width", maxrun, 4);
  endtask

  task automatic t_full;
    demand = 255; rlen = 10; dlen = 2;
    observe(30, 0);
    observe(120, 0);
    chk("R2 width capped by ramp", maxrun, 10);
    chk("R4 deadtime cycles", both_off, 20);
    chk("R3 overlap full duty", overlap, 0);
  endtask

  task automatic t_zero;
    demand = 0;
    observe(30, 0);
    observe(48, 0);
    chk("R11 zero demand on-cycles", ha + hb, 0);
    demand = 255;
    observe(30, 0);
  endtask

  task automatic wait_rise_a;
    int t = 0;
    logic p = a;
    forever begin
      @(negedge clk); t++;
      if ((a && !p) || t > 1000) break;
      p = a;
    end
  endtask

  task automatic t_pulldown;
    demand = 255; rlen = 10; dlen = 2;
    wait_rise_a();
    pd = 1;
    @(negedge clk);
    chk("R5 pulldown ends pulse", int'(a), 0);
    pd = 0;
    observe(20, 0);
    chk("R5 no restart in period", ha, 0);
    chk("R5 next period unaffected", hb, 10);
  endtask

  task automatic t_sync;
    demand = 255; rlen = 200; dlen = 2;
    observe(80, 20);
    observe(200, 20);
    chk("R6 ramp cut by sync", maxrun, 18);
    chk("R6 on-cycles with sync", ha + hb, 180);
    chk("R6 pulses with sync", rises, 10);
    rlen = 10;
    observe(250, 0);
  endtask

  task automatic t_shutdown;
    demand = 255; rlen = 10; dlen = 2;
    wait_rise_a();
    sd = 1;
    @(negedge clk);
    chk("R8 shutdown immediate", int'(a | b), 0);
    observe(30, 0);
    chk("R8 held off in shutdown", ha + hb, 0);
    sd = 0;
  endtask

  task automatic t_softstart;
    int len, which;
    int exp_runs[5] = '{2, 4, 6, 8, 10};
    uvlo = 1; demand = 255; rlen = 10; dlen = 2; step = 2;
    observe(30, 0);
    chk("R10 lockout on-cycles", ha + hb, 0);
    uvlo = 0;
    for (int k = 0; k < 5; k++) begin
      next_run(len, which);
      chk($sformatf("R9 soft-start pulse %0d", k), len, exp_runs[k]);
    end
    // soft-start is now 10; two period starts under shutdown remove 2*2 each
    sd = 1;
    observe(24, 0);
    chk("R8 off during discharge", ha + hb, 0);
    sd = 0;
    next_run(len, which);
    chk("R9 discharge at twice rate", len, 4);
    next_run(len, which);
    chk("R9 charge resumes", len, 6);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_full();
    t_zero();
    t_pulldown();
    t_sync();
    t_shutdown();
    t_softstart();
    chk("R7 polarity mismatches", pol_mis, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule